// File: doc/BRIEF.md
# Guarded Hardware Register Read Port

This block returns one of a handful of machine-state values to software running outside kernel mode, chosen by a 3-bit selector. Before any value is released, a per-selector permission check is made. Kernel mode always passes the check. Otherwise the selector's bit in a software-owned enable mask must be set. A read that fails the check returns no data and instead raises a one-cycle reserved-instruction exception strobe, which the pipeline turns into a trap.

The values on offer are the CPU number field of the exception base, the cache-line step used by cache-maintenance loops, and a free-running cycle counter kept inside the block. The cycle counter advances once every `CNT_RES` clocks. The other values are that resolution, performance counter 0, and a single extended-feature configuration bit. Results are registered: a request in one cycle produces either a valid strobe with data or an exception strobe in the next.

Top module: `hwreg_read_port`

## Requirements
- R1: A read of selector n (n from 0 to 5) is granted when `kern_mode` is 1 or `en_mask[n]` is 1. A granted read raises `rd_valid` for exactly one cycle, on the clock edge after the request, with `ri_exc` low.
- R2: A read of selector 0 to 5 in user mode with the matching mask bit clear raises `ri_exc` for one cycle, on the edge after the request. `rd_valid` stays low and `rd_data` is all zeros.
- R3: Selectors 6 and 7 hold no register. A read of either always raises `ri_exc`, whatever `kern_mode` and the mask are.
- R4: Selector 0 returns `cpu_id`, the CPU number field of the exception base, zero-extended to 64 bits.
- R5: Selector 1 returns `line_step`, zero-extended to 64 bits.
- R6: Selector 2 returns the 32-bit cycle counter as it stood on the request edge, sign-extended to 64 bits. Bit 31 is copied into bits 63..32.
- R7: The cycle counter loads `CNT_RST` on reset. After that it gains exactly 1 every `CNT_RES` clock cycles and wraps modulo 2^32.
- R8: Selector 3 returns the parameter `CNT_RES`, zero-extended.
- R9: Selector 4 returns `perf_cnt0` unchanged, all 64 bits.
- R10: Selector 5 returns `feat_cfg` in bit 0, with bits 63..1 zero.
- R11: A cycle with `rd_req` low leaves `rd_valid`, `ri_exc` and `rd_data` at zero on the next edge, whatever the other inputs are.
- R12: While `rst` is high, `rd_valid`, `ri_exc` and `rd_data` are zero. The first read after reset sees the counter at `CNT_RST`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, one cycle per read |
| rd_idx | input | 3 | Register selector |
| kern_mode | input | 1 | Kernel mode active, which bypasses the mask |
| en_mask | input | 6 | Per-selector user access enable |
| cpu_id | input | 10 | CPU number field of the exception base |
| line_step | input | 16 | Cache-line step size |
| perf_cnt0 | input | 64 | Performance counter 0 |
| feat_cfg | input | 1 | Extended-feature configuration bit |
| rd_valid | output | 1 | Granted read result strobe |
| ri_exc | output | 1 | Reserved-instruction exception strobe |
| rd_data | output | 64 | Read data, zero unless `rd_valid` is high |

## Verification
Every result in this block is due one clock edge after its request. Permission, selection and output all settle through a single output register, so the bench drives each request on a falling edge and checks all three outputs on the following falling edge. The counter value a read should return is taken from a model of R7 that the bench runs alongside. This model is snapshotted at the same falling edge that drives the request, because the design samples the counter on the rising edge between those two points. The counter starts just below the 32-bit sign boundary, so reads land on both sides of it. A mid-run reset then confirms that R12 returns the counter to its start value.

// File: rtl/hwrd_pkg.sv
package hwrd_pkg;

    localparam int XLEN   = 64;
    localparam int IDX_W  = 3;
    localparam int NSEL   = 1 << IDX_W;

    typedef enum logic [IDX_W-1:0] {
        SEL_CPUNUM = 3'd0,
        SEL_LSTEP  = 3'd1,
        SEL_CYCLE  = 3'd2,
        SEL_CRES   = 3'd3,
        SEL_PERF   = 3'd4,
        SEL_FEAT   = 3'd5,
        SEL_RSV6   = 3'd6,
        SEL_RSV7   = 3'd7
    } hw_sel_e;

    typedef struct packed {
        logic            valid;
        logic            exc;
        logic [XLEN-1:0] data;
    } rd_result_t;

    localparam rd_result_t RESULT_IDLE = '{valid: 1'b0, exc: 1'b0, data: '0};

    function automatic rd_result_t make_grant(input logic [XLEN-1:0] value);
        rd_result_t r;
        r.valid = 1'b1;
        r.exc   = 1'b0;
        r.data  = value;
        return r;
    endfunction

    function automatic rd_result_t make_trap();
        rd_result_t r;
        r.valid = 1'b0;
        r.exc   = 1'b1;
        r.data  = '0;
        return r;
    endfunction

endpackage

// File: rtl/hwrd_cycle_counter.sv
module hwrd_cycle_counter #(
    parameter int          CNT_W   = 32,
    parameter int          CNT_RES = 2,
    parameter logic [31:0] CNT_RST = 32'd0
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int PW = (CNT_RES > 1) ? $clog2(CNT_RES) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    generate
        if (CNT_RES > 1) begin : g_prescale
            localparam logic [PW-1:0] LAST = PW'(CNT_RES - 1);
            logic [PW-1:0] presc_q;

            assign tick = (presc_q == LAST);

            always_ff @(posedge clk) begin
                if (rst) begin
                    presc_q <= '0;
                end else if (tick) begin
                    presc_q <= '0;
                end else begin
                    presc_q <= presc_q + 1'b1;
                end
            end

            // R7: between ticks the count holds still
            p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (rst)
                (presc_q != LAST) |=> (cnt_q == $past(cnt_q)));
        end else begin : g_every_cycle
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(CNT_RST);
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R7: each tick adds exactly one
    p_step_by_one_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/hwrd_access_gate.sv
module hwrd_access_gate
    import hwrd_pkg::*;
#(
    parameter int MASK_W = 6
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              kern_mode,
    input  logic [MASK_W-1:0] en_mask,
    output logic              allow_o
);

    logic [NSEL-1:0] grant_vec;

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_sel
            if (g < MASK_W) begin : g_impl
                assign grant_vec[g] = kern_mode | en_mask[g];
            end else begin : g_rsv
                assign grant_vec[g] = 1'b0;
            end
        end
    endgenerate

    assign allow_o = grant_vec[idx];

    // R3: unimplemented selectors never pass, even in kernel mode
    always_comb begin
        if (int'(idx) >= MASK_W) begin
            a_rsv_denied_r3: assert (!allow_o);
        end
    end

endmodule

// File: rtl/hwrd_value_mux.sv
module hwrd_value_mux
    import hwrd_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int CNT_RES  = 2,
    parameter int STEP_W   = 16,
    parameter int CPUNUM_W = 10
) (
    input  logic [IDX_W-1:0]    idx,
    input  logic [CPUNUM_W-1:0] cpu_id,
    input  logic [STEP_W-1:0]   line_step,
    input  logic [CNT_W-1:0]    cycle_cnt,
    input  logic [XLEN-1:0]     perf_cnt0,
    input  logic                feat_cfg,
    output logic [XLEN-1:0]     value_o
);

    localparam logic [XLEN-1:0] RES_VALUE = XLEN'(CNT_RES);

    logic [XLEN-1:0] cycle_sext;

    assign cycle_sext = {{(XLEN-CNT_W){cycle_cnt[CNT_W-1]}}, cycle_cnt};

    always_comb begin
        unique case (hw_sel_e'(idx))
            SEL_CPUNUM: value_o = XLEN'(cpu_id);
            SEL_LSTEP:  value_o = XLEN'(line_step);
            SEL_CYCLE:  value_o = cycle_sext;
            SEL_CRES:   value_o = RES_VALUE;
            SEL_PERF:   value_o = perf_cnt0;
            SEL_FEAT:   value_o = XLEN'(feat_cfg);
            default:    value_o = '0;
        endcase
    end

endmodule

// File: rtl/hwreg_read_port.sv
module hwreg_read_port
    import hwrd_pkg::*;
#(
    parameter int          CNT_W    = 32,
    parameter int          CNT_RES  = 2,
    parameter logic [31:0] CNT_RST  = 32'd0,
    parameter int          STEP_W   = 16,
    parameter int          CPUNUM_W = 10,
    parameter int          MASK_W   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_req,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic                kern_mode,
    input  logic [MASK_W-1:0]   en_mask,
    input  logic [CPUNUM_W-1:0] cpu_id,
    input  logic [STEP_W-1:0]   line_step,
    input  logic [XLEN-1:0]     perf_cnt0,
    input  logic                feat_cfg,
    output logic                rd_valid,
    output logic                ri_exc,
    output logic [XLEN-1:0]     rd_data
);

    logic [CNT_W-1:0] cycle_cnt;
    logic             allow;
    logic [XLEN-1:0]  sel_value;
    rd_result_t       res_q;

    hwrd_cycle_counter #(
        .CNT_W   (CNT_W),
        .CNT_RES (CNT_RES),
        .CNT_RST (CNT_RST)
    ) u_counter (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cycle_cnt)
    );

    hwrd_access_gate #(
        .MASK_W (MASK_W)
    ) u_gate (
        .idx       (rd_idx),
        .kern_mode (kern_mode),
        .en_mask   (en_mask),
        .allow_o   (allow)
    );

    hwrd_value_mux #(
        .CNT_W    (CNT_W),
        .CNT_RES  (CNT_RES),
        .STEP_W   (STEP_W),
        .CPUNUM_W (CPUNUM_W)
    ) u_mux (
        .idx       (rd_idx),
        .cpu_id    (cpu_id),
        .line_step (line_step),
        .cycle_cnt (cycle_cnt),
        .perf_cnt0 (perf_cnt0),
        .feat_cfg  (feat_cfg),
        .value_o   (sel_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= RESULT_IDLE;
        end else if (!rd_req) begin
            res_q <= RESULT_IDLE;
        end else if (allow) begin
            res_q <= make_grant(sel_value);
        end else begin
            res_q <= make_trap();
        end
    end

    assign rd_valid = res_q.valid;
    assign ri_exc   = res_q.exc;
    assign rd_data  = res_q.data;

    // R2: a trap carries no data and no valid
    p_trap_clean_r2: assert property (@(posedge clk) disable iff (rst)
        ri_exc |-> (!rd_valid && rd_data == '0));

    // R11: no request, no result on the next edge
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> (!rd_valid && !ri_exc && rd_data == '0));

    // R1: kernel mode reads of implemented selectors are always granted
    p_kernel_grant_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && kern_mode && int'(rd_idx) < MASK_W) |=> (rd_valid && !ri_exc));

    // R3: reserved selectors always trap
    p_rsv_trap_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && int'(rd_idx) >= MASK_W) |=> ri_exc);

    // R12: outputs are clear on the edge after reset is applied
    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (!rd_valid && !ri_exc && rd_data == '0));

endmodule

// File: tb/hwreg_read_port_bench.sv
`timescale 1ns/1ps
module hwreg_read_port_bench;

    localparam int          CNT_RES  = 2;
    localparam logic [31:0] CNT_RST  = 32'h7FFF_FFF0;
    localparam logic [9:0]  CPU_ID   = 10'h2A5;
    localparam logic [15:0] STEP     = 16'h0040;
    localparam logic [63:0] PERF     = 64'hDEAD_BEEF_0123_4567;

    typedef struct packed {
        logic [2:0] idx;
        logic       kern;
        logic [5:0] mask;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 6'b000001},
        '{3'd1, 1'b0, 6'b000010},
        '{3'd2, 1'b0, 6'b000100},
        '{3'd3, 1'b0, 6'b001000},
        '{3'd4, 1'b0, 6'b010000},
        '{3'd5, 1'b0, 6'b100000},
        '{3'd0, 1'b0, 6'b111110},
        '{3'd2, 1'b0, 6'b111011},
        '{3'd5, 1'b0, 6'b011111},
        '{3'd4, 1'b1, 6'b000000},
        '{3'd1, 1'b1, 6'b000000},
        '{3'd6, 1'b1, 6'b111111},
        '{3'd7, 1'b0, 6'b111111},
        '{3'd3, 1'b0, 6'b111111},
        '{3'd2, 1'b1, 6'b000000},
        '{3'd5, 1'b0, 6'b000000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic        kern_mode = 1'b0;
    logic [5:0]  en_mask = '0;
    logic        feat_cfg = 1'b1;
    logic        rd_valid;
    logic        ri_exc;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hwreg_read_port #(
        .CNT_RES (CNT_RES),
        .CNT_RST (CNT_RST)
    ) u_hwreg_read_port (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .rd_idx    (rd_idx),
        .kern_mode (kern_mode),
        .en_mask   (en_mask),
        .cpu_id    (CPU_ID),
        .line_step (STEP),
        .perf_cnt0 (PERF),
        .feat_cfg  (feat_cfg),
        .rd_valid  (rd_valid),
        .ri_exc    (ri_exc),
        .rd_data   (rd_data)
    );

    // Counter model from R7: loads CNT_RST, gains one every CNT_RES clocks
    int          m_pre;
    logic [31:0] m_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            m_pre <= 0;
            m_cnt <= CNT_RST;
        end else if (m_pre == CNT_RES - 1) begin
            m_pre <= 0;
            m_cnt <= m_cnt + 1;
        end else begin
            m_pre <= m_pre + 1;
        end
    end

    function automatic string req_tag(input logic [2:0] idx, input bit grant);
        if (idx >= 3'd6) return "R3";
        if (!grant)      return "R2";
        case (idx)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R8";
            3'd4: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [63:0] exp_value(input logic [2:0] idx, input logic [31:0] cyc,
                                              input logic feat);
        case (idx)
            3'd0: return {54'd0, CPU_ID};
            3'd1: return {48'd0, STEP};
            3'd2: return {{32{cyc[31]}}, cyc};
            3'd3: return 64'(CNT_RES);
            3'd4: return PERF;
            3'd5: return {63'd0, feat};
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {valid,exc,data} actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One read: drive on a falling edge, check on the next falling edge
    task automatic do_read(input logic [2:0] idx, input logic kern, input logic [5:0] mask,
                           input string extra);
        bit          grant;
        logic [31:0] cyc;
        logic [65:0] exp;
        @(negedge clk);
        rd_req    = 1'b1;
        rd_idx    = idx;
        kern_mode = kern;
        en_mask   = mask;
        cyc       = m_cnt;
        grant     = (idx < 3'd6) && (kern || mask[idx]);
        exp       = grant ? {1'b1, 1'b0, exp_value(idx, cyc, feat_cfg)} : {1'b0, 1'b1, 64'd0};
        @(negedge clk);
        check({req_tag(idx, grant), extra}, {rd_valid, ri_exc, rd_data}, exp);
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs clear under reset
        check("R12 reset", {rd_valid, ri_exc, rd_data}, 66'd0);
        rst = 1'b0;
        // R12/R6: first read sees the counter start value, still positive
        do_read(3'd2, 1'b1, 6'd0, " R12 first count");

        // Table walk: R1 grants, R2 denials, R3 reserved selectors, R4-R10 values
        for (int i = 0; i < NVEC; i++) begin
            do_read(VECS[i].idx, VECS[i].kern, VECS[i].mask, " R1 table");
        end

        // R6: counter has crossed bit 31, upper half must be all ones
        do_read(3'd2, 1'b0, 6'b000100, " R6 negative");
        // R7: back-to-back counter reads follow the model step rate
        do_read(3'd2, 1'b0, 6'b000100, " R7 step a");
        do_read(3'd2, 1'b0, 6'b000100, " R7 step b");
        repeat (5) @(negedge clk);
        do_read(3'd2, 1'b1, 6'b000000, " R7 gap");

        // R10: feature bit cleared
        feat_cfg = 1'b0;
        do_read(3'd5, 1'b1, 6'b000000, " feat zero");
        feat_cfg = 1'b1;

        // R11: idle cycle with every other input busy
        @(negedge clk);
        rd_req = 1'b0; rd_idx = 3'd4; kern_mode = 1'b1; en_mask = 6'b111111;
        @(negedge clk);
        check("R11 idle", {rd_valid, ri_exc, rd_data}, 66'd0);

        // R12: mid-run reset returns outputs to zero and the counter to its start
        rd_req = 1'b1; rd_idx = 3'd4;
        rst = 1'b1;
        @(negedge clk);
        check("R12 midrun", {rd_valid, ri_exc, rd_data}, 66'd0);
        rd_req = 1'b0;
        rst = 1'b0;
        do_read(3'd2, 1'b1, 6'd0, " R12 count restart");
        check("R12 start value", {rd_valid, ri_exc, rd_data},
              {1'b1, 1'b0, {32'd0, CNT_RST}});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule